// File: doc/BRIEF.md
# Register-Init Command Table Interpreter

This block executes a register initialisation script that sits in a word-addressed table memory. A start pulse hands it a base address, a table length in words and a poll limit. The block then fetches 32-bit words one after another and decodes each command. It performs register writes, read-modify-writes, polls and indexed writes on a simple request/ready register bus. It stops when it reaches an end command.

Commands are variable-length. The header word carries a 4-bit opcode in bits [31:28], and zero to two operand words follow it. The block reports completion with a one-cycle `done` pulse and failure with a one-cycle `error` pulse. The number of table words it has consumed stays on `words_used` until the next start, so that software can compare it with the size it built.

Top module: `cmd_table_walker`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `mem_rd_en`, `bus_rd` and `bus_wr` are all low.
- R2: Opcode 0 is a direct write of two words: the header, then the value. It issues one bus write to offset header[27:0] with index space 0.
- R3: Opcode 8 is an indexed write of two words: the header, then the value. It writes to offset header[19:0] with `bus_space` = header[27:20].
- R4: Opcode 3 is a read-modify-write of three words: the header, the data, then the mask. It makes exactly one bus read of header[27:0], then writes back (old & ~mask) | (data & mask).
- R5: Opcode 2 is a poll of three words: the header, the mask, then the expected value. It re-reads header[27:0] until (rdata & mask) == expected. A match on the last read that the limit allows completes normally.
- R6: A poll raises `error` and halts once the number of mismatching reads reaches `poll_limit` (a value of 0 behaves like 1).
- R7: Opcode 0xF is a single-word end command. It produces one `done` pulse with `busy` low, and `words_used` then counts every word fetched, the end word included.
- R8: Any other opcode raises `error` and halts with no bus access for that command or for any later one.
- R9: If the block needs a word at index `table_len` or beyond, it raises `error` and halts. No table read happens past the length.
- R10: A bus read or write request stays asserted with a stable address until `bus_ready`, and `bus_rd` and `bus_wr` are never high together.
- R11: A start pulse while `busy` is high is ignored.
- R12: `done` and `error` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking a table (ignored while busy) |
| base_addr | input | AW | First word address of the table |
| table_len | input | AW | Table length in words |
| poll_limit | input | TW | Mismatching poll reads allowed |
| mem_rd_en | output | 1 | Table read strobe |
| mem_addr | output | AW | Table read address |
| mem_rdata | input | 32 | Table word, valid one cycle after the strobe |
| bus_rd | output | 1 | Register read request |
| bus_wr | output | 1 | Register write request |
| bus_addr | output | 28 | Register offset |
| bus_space | output | 8 | Index space (0 for direct commands) |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data, taken when ready |
| bus_ready | input | 1 | Completes the current request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse on reaching the end command |
| error | output | 1 | One-cycle pulse on a fault |
| words_used | output | AW | Words consumed by the last walk |

## Verification
Two decisions can land on a single bus cycle: a poll read can match its expected value and also exhaust the poll limit. The bench sets the limit to three reads and makes the register return the matching value on exactly the third read. It passes only if `done` fires and `error` stays low. A second overlap is a new start pulse that arrives while a long poll is still running. This is judged by checking that the first table still finishes with its own word count and its own outcome.

// File: rtl/cmd_table_walker.sv
module cmd_table_walker #(
  parameter int AW = 12,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] table_len,
  input  logic [TW-1:0] poll_limit,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [27:0]   bus_addr,
  output logic [7:0]    bus_space,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ready,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] words_used
);
  localparam logic [3:0] OP_WR = 4'h0, OP_POLL = 4'h2, OP_RMW = 4'h3, OP_IND = 4'h8, OP_END = 4'hF;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_CAP, S_RD, S_WR} st_t;

  st_t           st;
  logic [AW-1:0] base, len, ptr;
  logic [TW-1:0] lim, pcnt;
  logic [1:0]    idx;
  logic [31:0]   hdr, w1, w2, wdat;
  logic          done_q, err_q;

  wire [3:0] op     = hdr[31:28];
  wire [3:0] op_new = mem_rdata[31:28];
  wire       three  = (op == OP_POLL) || (op == OP_RMW);
  wire       at_end = (ptr == len);
  wire       hit    = ((bus_rdata & w1) == w2);
  wire       expire = ({1'b0, pcnt} + 1'b1) >= {1'b0, lim};

  assign busy       = (st != S_IDLE);
  assign mem_rd_en  = (st == S_REQ) && !at_end;
  assign mem_addr   = base + ptr;
  assign bus_rd     = (st == S_RD);
  assign bus_wr     = (st == S_WR);
  assign bus_addr   = (op == OP_IND) ? {8'h00, hdr[19:0]} : hdr[27:0];
  assign bus_space  = (op == OP_IND) ? hdr[27:20] : 8'h00;
  assign bus_wdata  = wdat;
  assign done       = done_q;
  assign error      = err_q;
  assign words_used = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; len <= '0; ptr <= '0; lim <= '0; pcnt <= '0;
      idx <= '0; hdr <= '0; w1 <= '0; w2 <= '0; wdat <= '0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base <= base_addr; len <= table_len; lim <= poll_limit;
          ptr <= '0; idx <= '0; st <= S_REQ;
        end
        S_REQ: begin
          if (at_end) begin err_q <= 1'b1; st <= S_IDLE; end
          else st <= S_CAP;
        end
        S_CAP: begin
          ptr <= ptr + 1'b1;
          if (idx == 2'd0) begin
            hdr <= mem_rdata;
            case (op_new)
              OP_END:                      begin done_q <= 1'b1; st <= S_IDLE; end
              OP_WR, OP_POLL, OP_RMW, OP_IND: begin idx <= 2'd1; st <= S_REQ; end
              default:                     begin err_q <= 1'b1; st <= S_IDLE; end
            endcase
          end else if (idx == 2'd1) begin
            w1 <= mem_rdata;
            if (three) begin idx <= 2'd2; st <= S_REQ; end
            else begin wdat <= mem_rdata; st <= S_WR; end
          end else begin
            w2 <= mem_rdata; pcnt <= '0; st <= S_RD;
          end
        end
        S_RD: if (bus_ready) begin
          if (op == OP_POLL) begin
            if (hit) begin idx <= '0; st <= S_REQ; end
            else if (expire) begin err_q <= 1'b1; st <= S_IDLE; end
            else pcnt <= pcnt + 1'b1;
          end else begin
            wdat <= (bus_rdata & ~w2) | (w1 & w2);
            st <= S_WR;
          end
        end
        S_WR: if (bus_ready) begin idx <= '0; st <= S_REQ; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_rdwr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr));
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));
  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));
  assert_done_err_excl_R12: assert property (@(posedge clk) disable iff (!rst_n) !(done && error));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (words_used <= len));
  assert_no_fetch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |-> busy);
endmodule

// File: tb/cmd_table_walker_test.sv
module cmd_table_walker_test;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [11:0] base_addr = '0, table_len = '0;
  logic [15:0] poll_limit = '0;
  logic        mem_rd_en, bus_rd, bus_wr, busy, done, error;
  logic [11:0] mem_addr, words_used;
  logic [31:0] mem_rdata = '0, bus_wdata, bus_rdata;
  logic [27:0] bus_addr;
  logic [7:0]  bus_space;
  logic        bus_ready = 1'b0;

  cmd_table_walker uut (.*);

  always #4 clk = ~clk;

  logic [31:0] mem [0:63];
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[5:0]];

  int tests = 0, fails = 0, cyc = 0;
  int pollcnt = 0, poll_base = 0, rdn = 0, nlog = 0, overlap = 0, bothpulse = 0;
  logic [7:0]  log_sp [0:63];
  logic [27:0] log_ad [0:63];
  logic [31:0] log_dt [0:63];

  assign bus_rdata = (bus_addr == 28'h100) ? 32'(pollcnt - poll_base + 1) :
                     (bus_addr == 28'h2)   ? 32'hAAAA5555 : 32'h0;

  always @(posedge clk) begin
    if (!rst_n) bus_ready <= 1'b0;
    else begin
      bus_ready <= (bus_rd || bus_wr) && !bus_ready;
      if (bus_ready && bus_rd) begin
        rdn <= rdn + 1;
        if (bus_addr == 28'h100) pollcnt <= pollcnt + 1;
      end
      if (bus_ready && bus_wr) begin
        log_sp[nlog[5:0]] <= bus_space; log_ad[nlog[5:0]] <= bus_addr;
        log_dt[nlog[5:0]] <= bus_wdata; nlog <= nlog + 1;
      end
      if (bus_rd && bus_wr) overlap <= overlap + 1;
      if (done && error) bothpulse <= bothpulse + 1;
    end
  end

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  logic got_d, got_e;
  int   l0, r0;

  task automatic kick(input logic [11:0] b, input logic [11:0] l, input logic [15:0] lim);
    @(negedge clk);
    l0 = nlog; r0 = rdn; poll_base = pollcnt;
    base_addr = b; table_len = l; poll_limit = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_wait();
    got_d = 1'b0; got_e = 1'b0;
    for (int n = 0; n < 2000 && !got_d && !got_e; n++) begin
      if (done) got_d = 1'b1;
      if (error) got_e = 1'b1;
      if (!got_d && !got_e) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0); chk("R1", "done", done, 0); chk("R1", "error", error, 0);
    chk("R1", "rd/wr/fetch", {mem_rd_en, bus_rd, bus_wr}, 0);
  endtask

  task automatic t_writes();
    kick(12'd0, 12'd5, 16'd4); finish_wait();
    chk("R7", "done", got_d, 1); chk("R7", "error", got_e, 0);
    chk("R7", "words", words_used, 5); chk("R7", "busy with done", busy, 0);
    chk("R2", "write count", nlog - l0, 2);
    chk("R2", "addr", log_ad[l0], 28'h0000005); chk("R2", "space", log_sp[l0], 0);
    chk("R2", "data", log_dt[l0], 32'hDEADBEEF);
    chk("R3", "addr", log_ad[l0+1], 28'h0000007); chk("R3", "space", log_sp[l0+1], 8'h03);
    chk("R3", "data", log_dt[l0+1], 32'h00001234);
  endtask

  task automatic t_rmw();
    kick(12'd8, 12'd4, 16'd4); finish_wait();
    chk("R4", "done", got_d, 1); chk("R4", "reads", rdn - r0, 1);
    chk("R4", "writes", nlog - l0, 1); chk("R4", "addr", log_ad[l0], 28'h2);
    chk("R4", "merged", log_dt[l0], 32'hAA0F0F55); chk("R4", "words", words_used, 4);
  endtask

  task automatic t_poll_edge();
    kick(12'd16, 12'd4, 16'd3); finish_wait();
    chk("R5", "done on last allowed read", got_d, 1); chk("R5", "error", got_e, 0);
    chk("R5", "reads", rdn - r0, 3); chk("R5", "words", words_used, 4);
  endtask

  task automatic t_poll_timeout();
    kick(12'd16, 12'd4, 16'd2); finish_wait();
    chk("R6", "error", got_e, 1); chk("R6", "done", got_d, 0);
    chk("R6", "reads", rdn - r0, 2); chk("R6", "words", words_used, 3);
  endtask

  task automatic t_badop();
    kick(12'd24, 12'd3, 16'd2); finish_wait();
    chk("R8", "error", got_e, 1); chk("R8", "words", words_used, 1);
    repeat (10) @(negedge clk);
    chk("R8", "no bus access", (nlog - l0) + (rdn - r0), 0); chk("R8", "halted", busy, 0);
  endtask

  task automatic t_overrun();
    kick(12'd32, 12'd2, 16'd2); finish_wait();
    chk("R9", "error", got_e, 1); chk("R9", "words", words_used, 2);
    chk("R9", "write done before overrun", nlog - l0, 1);
    kick(12'd32, 12'd1, 16'd2); finish_wait();
    chk("R9", "truncated error", got_e, 1); chk("R9", "truncated words", words_used, 1);
    chk("R9", "truncated no write", nlog - l0, 0);
  endtask

  task automatic t_restart_busy();
    kick(12'd40, 12'd4, 16'd10);
    repeat (12) @(negedge clk);
    chk("R11", "busy mid-poll", busy, 1);
    base_addr = 12'd24; table_len = 12'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_wait();
    chk("R11", "first table done", got_d, 1); chk("R11", "no error", got_e, 0);
    chk("R11", "words", words_used, 4); chk("R11", "reads", rdn - r0, 5);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hF000_0000;
    mem[0] = 32'h0000_0005; mem[1] = 32'hDEADBEEF;
    mem[2] = 32'h8030_0007; mem[3] = 32'h0000_1234; mem[4] = 32'hF000_0000;
    mem[8] = 32'h3000_0002; mem[9] = 32'h0F0F_0F0F; mem[10] = 32'h00FF_FF00; mem[11] = 32'hF000_0000;
    mem[16] = 32'h2000_0100; mem[17] = 32'h0000_00FF; mem[18] = 32'h0000_0003; mem[19] = 32'hF000_0000;
    mem[24] = 32'h5000_0000; mem[25] = 32'h0000_0001; mem[26] = 32'hF000_0000;
    mem[32] = 32'h0000_0009; mem[33] = 32'h0000_0042;
    mem[40] = 32'h2000_0100; mem[41] = 32'h0000_00FF; mem[42] = 32'h0000_0005; mem[43] = 32'hF000_0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_writes();
    t_rmw();
    t_poll_edge();
    t_poll_timeout();
    t_badop();
    t_overrun();
    t_restart_busy();
    chk("R10", "rd/wr overlap cycles", overlap, 0);
    chk("R12", "done+error cycles", bothpulse, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end
endmodule